// File: doc/BRIEF.md
# Interruptible Vector Element Sequencer

This block steps one interruptible vector instruction through its elements. A start pulse gives it a restart index, the vector count, the section size, the instruction address and length, the program-mask bits and a description of where the result lands. It then offers one element operation at a time to an external datapath over a valid/ready handshake. That datapath returns an exception code for the element in the same cycle it accepts the operation. Each accepted element is one unit of operation, so an interruption can only fall between two accepted elements.

The block recognises exceptions element by element, in order. Exceptions whose program-mask bit is clear are discarded. The first exception that is left stops the instruction. The block classifies that stop as one of four endings: completion, inhibition, nullification or suppression. It reports the ending together with the adjusted element index, the address the program must continue from, and a 16-bit interruption code. If the last element runs without a stop, a final unit of operation follows. It advances the address, clears the saved index and never interrupts. Starting the block again with the saved index resumes exactly where it stopped.

The controller has four states:
- IDLE waits for start.
- ISSUE offers the current element.
- FINAL performs the final unit.
- TRAP presents an interruption.

It has these transitions:
- IDLE→ISSUE: start with index below the limit.
- IDLE→FINAL: start with index at or above the limit.
- ISSUE→ISSUE: element accepted clean, more remain.
- ISSUE→FINAL: last element accepted clean.
- ISSUE→TRAP: accepted element raises an unmasked exception.
- FINAL→IDLE and TRAP→IDLE: always, after one cycle.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset the block is in IDLE: `op_valid`, `done`, `intr` and `wr_en` are low, and `save_idx`, `next_ia` and `int_code` are zero.
- R2: After start, elements are offered on `op_idx` in ascending order beginning at `start_idx`. The index advances only on a cycle with `op_valid` and `op_ready` both high. While `op_ready` is low, `op_valid` and `op_idx` hold.
- R3: The element limit is the smaller of `vec_count` and `sect_size`. If `start_idx` is at or above the limit, no element is offered, and `done` rises in the cycle after the start edge.
- R4: The final unit raises `done` for exactly one cycle with `save_idx` = 0, `next_ia` = `inst_addr` + `inst_len`, `int_code` = 0 and `end_kind` = 0. It follows the acceptance of the last element, which is element limit−1.
- R5: Exception codes on `op_exc` are 0 none, 1 fixed-point overflow, 2 exponent overflow, 3 exponent underflow, 4 significance, 5 divide, 6 unnormalized operand, 7 access (nullifying) and 8 access (suppressing). Codes 9–15 mean no exception. Codes 1, 3 and 4 are enabled by `prog_mask` bits 0, 1 and 2 respectively. With the bit clear, the element is treated as clean: it is written and nothing is reported.
- R6: Codes 2, and 1, 3 or 4 when enabled, end by completion (`end_kind` 0). The element is written, `save_idx` = element+1 and `next_ia` = `inst_addr`.
- R7: Codes 5 and 6 end by inhibition (`end_kind` 1). The element is not written, `save_idx` = element+1 and `next_ia` = `inst_addr`.
- R8: Code 7 ends by nullification (`end_kind` 2). The element is not written, `save_idx` = element and `next_ia` = `inst_addr`.
- R9: Code 8 ends by suppression (`end_kind` 3). The element is not written, `save_idx` = element and `next_ia` = `inst_addr` + `inst_len`.
- R10: `intr` is a one-cycle pulse in the cycle after the faulting acceptance, and no further element is offered. `int_code[7:0]` holds the exception type: 0x09, 0x0C, 0x0D, 0x0E, 0x0F, 0x1E, 0x11 and 0x04 for codes 1 to 8. For codes 1–6, `int_code[15:8]` is {1, `res_vec`, width, `res_reg`}, where width is 2'b10 when `res_long` is 1 and 2'b01 otherwise. For codes 7–8 the upper byte is zero.
- R11: `wr_en` is high exactly on an accepted element that is clean or ends by completion.
- R12: A restart at `save_idx` after any ending, with the fault removed, leads to every element from the original start to limit−1 being processed exactly once. Processed means written or inhibited. A fault on element limit−1 ending by completion or inhibition gives `save_idx` equal to the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (sampled in IDLE) |
| start_idx | input | IDX_W+1 | Restart element index |
| vec_count | input | IDX_W+1 | Vector count |
| sect_size | input | IDX_W+1 | Section size |
| inst_addr | input | ADDR_W | Address of the instruction |
| inst_len | input | LEN_W | Instruction length in bytes |
| prog_mask | input | 3 | Enables: [0] fixed overflow, [1] exponent underflow, [2] significance |
| res_vec | input | 1 | Result lands in vector registers |
| res_long | input | 1 | Result is 8 bytes wide |
| res_reg | input | 4 | Result register number |
| op_valid | output | 1 | Element operation offered |
| op_idx | output | IDX_W+1 | Element index offered |
| op_ready | input | 1 | Datapath accepts the element |
| op_exc | input | 4 | Exception code for the accepted element |
| wr_en | output | 1 | Commit the accepted element's result |
| done | output | 1 | Final unit performed |
| intr | output | 1 | Interruption taken |
| end_kind | output | 2 | 0 completion, 1 inhibition, 2 nullification, 3 suppression |
| save_idx | output | IDX_W+1 | Adjusted element index |
| next_ia | output | ADDR_W | Address to continue from |
| int_code | output | 16 | Interruption code |

## Verification
A corrupted element counter shows up at once on `op_idx`, the next time an element is offered. It also shows up as a skipped or repeated element when the run is resumed. A wrong transition out of ISSUE shows up within one cycle of the faulting acceptance: `done` and `intr` swap, or an extra element is offered. A misclassified ending shows up in the same cycle as `intr`, as a wrong `save_idx`, a wrong `next_ia` or a stray `wr_en`.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [1:0] {
        END_COMPLETE = 2'd0,
        END_INHIBIT  = 2'd1,
        END_NULLIFY  = 2'd2,
        END_SUPPRESS = 2'd3
    } end_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_FINAL = 2'd2,
        S_TRAP  = 2'd3
    } seq_state_e;

    localparam logic [3:0] EXC_NONE    = 4'd0;
    localparam logic [3:0] EXC_FXOV    = 4'd1;
    localparam logic [3:0] EXC_EXPOV   = 4'd2;
    localparam logic [3:0] EXC_EXPUND  = 4'd3;
    localparam logic [3:0] EXC_SIGNIF  = 4'd4;
    localparam logic [3:0] EXC_FPDIV   = 4'd5;
    localparam logic [3:0] EXC_UNNORM  = 4'd6;
    localparam logic [3:0] EXC_ACC_NUL = 4'd7;
    localparam logic [3:0] EXC_ACC_SUP = 4'd8;

    localparam logic [7:0] TY_FXOV    = 8'h09;
    localparam logic [7:0] TY_EXPOV   = 8'h0C;
    localparam logic [7:0] TY_EXPUND  = 8'h0D;
    localparam logic [7:0] TY_SIGNIF  = 8'h0E;
    localparam logic [7:0] TY_FPDIV   = 8'h0F;
    localparam logic [7:0] TY_UNNORM  = 8'h1E;
    localparam logic [7:0] TY_ACC_NUL = 8'h11;
    localparam logic [7:0] TY_ACC_SUP = 8'h04;

endpackage

// File: rtl/vseq_classify.sv
module vseq_classify
    import vseq_pkg::*;
(
    input  logic [3:0] exc,
    input  logic [2:0] pmask,
    output logic       take,
    output end_kind_e  kind,
    output logic       write_ok,
    output logic       arith,
    output logic [7:0] type_byte
);

    always_comb begin
        take      = 1'b0;
        kind      = END_COMPLETE;
        arith     = 1'b0;
        type_byte = 8'h00;
        case (exc)
            EXC_FXOV: begin
                take = pmask[0]; arith = 1'b1; type_byte = TY_FXOV;
            end
            EXC_EXPOV: begin
                take = 1'b1; arith = 1'b1; type_byte = TY_EXPOV;
            end
            EXC_EXPUND: begin
                take = pmask[1]; arith = 1'b1; type_byte = TY_EXPUND;
            end
            EXC_SIGNIF: begin
                take = pmask[2]; arith = 1'b1; type_byte = TY_SIGNIF;
            end
            EXC_FPDIV: begin
                take = 1'b1; arith = 1'b1; kind = END_INHIBIT; type_byte = TY_FPDIV;
            end
            EXC_UNNORM: begin
                take = 1'b1; arith = 1'b1; kind = END_INHIBIT; type_byte = TY_UNNORM;
            end
            EXC_ACC_NUL: begin
                take = 1'b1; kind = END_NULLIFY; type_byte = TY_ACC_NUL;
            end
            EXC_ACC_SUP: begin
                take = 1'b1; kind = END_SUPPRESS; type_byte = TY_ACC_SUP;
            end
            default: begin
                take = 1'b0;
            end
        endcase
        // masked or absent exceptions leave a clean element
        write_ok = !take || (kind == END_COMPLETE);
    end

endmodule

// File: rtl/vseq_code_pack.sv
module vseq_code_pack (
    input  logic        take,
    input  logic        arith,
    input  logic        res_vec,
    input  logic        res_long,
    input  logic [3:0]  res_reg,
    input  logic [7:0]  type_byte,
    output logic [15:0] code
);

    logic [7:0] ext_byte;

    always_comb begin
        ext_byte = 8'h00;
        if (arith) begin
            ext_byte = {1'b1, res_vec, (res_long ? 2'b10 : 2'b01), res_reg};
        end
        code = take ? {ext_byte, type_byte} : 16'h0000;
    end

    // R10
    always_comb begin
        if (take && arith) begin
            r10_ext_flag_chk: assert (code[15] && (code[13:12] != 2'b00));
        end
    end

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W:0]    start_idx,
    input  logic [IDX_W:0]    vec_count,
    input  logic [IDX_W:0]    sect_size,
    input  logic [ADDR_W-1:0] inst_addr,
    input  logic [LEN_W-1:0]  inst_len,
    input  logic [2:0]        prog_mask,
    input  logic              res_vec,
    input  logic              res_long,
    input  logic [3:0]        res_reg,
    output logic              op_valid,
    output logic [IDX_W:0]    op_idx,
    input  logic              op_ready,
    input  logic [3:0]        op_exc,
    output logic              wr_en,
    output logic              done,
    output logic              intr,
    output logic [1:0]        end_kind,
    output logic [IDX_W:0]    save_idx,
    output logic [ADDR_W-1:0] next_ia,
    output logic [15:0]       int_code
);

    localparam int CNT_W = IDX_W + 1;

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  idx_q, lim_q, save_q;
    logic [ADDR_W-1:0] ia_q, nia_q;
    logic [LEN_W-1:0]  len_q;
    logic [2:0]        pm_q;
    logic              rv_q, rl_q;
    logic [3:0]        rr_q;
    logic [15:0]       code_q;
    end_kind_e         kind_q;

    logic [CNT_W-1:0]  start_lim;
    logic [CNT_W-1:0]  idx_inc;
    logic              fire;
    logic              last_elem;
    logic              cls_take, cls_write, cls_arith;
    end_kind_e         cls_kind;
    logic [7:0]        cls_type;
    logic [15:0]       cls_code;

    assign start_lim = (vec_count > sect_size) ? sect_size : vec_count;
    assign idx_inc   = idx_q + 1'b1;
    assign fire      = (state_q == S_ISSUE) && op_ready;
    assign last_elem = (idx_inc >= lim_q);

    vseq_classify u_cls (
        .exc       (op_exc),
        .pmask     (pm_q),
        .take      (cls_take),
        .kind      (cls_kind),
        .write_ok  (cls_write),
        .arith     (cls_arith),
        .type_byte (cls_type)
    );

    vseq_code_pack u_pack (
        .take      (cls_take),
        .arith     (cls_arith),
        .res_vec   (rv_q),
        .res_long  (rl_q),
        .res_reg   (rr_q),
        .type_byte (cls_type),
        .code      (cls_code)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = (start_idx >= start_lim) ? S_FINAL : S_ISSUE;
                end
            end
            S_ISSUE: begin
                if (fire) begin
                    if (cls_take) begin
                        state_d = S_TRAP;
                    end else if (last_elem) begin
                        state_d = S_FINAL;
                    end
                end
            end
            S_FINAL: state_d = S_IDLE;
            S_TRAP:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // operand parameters and ending fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            lim_q  <= '0;
            ia_q   <= '0;
            len_q  <= '0;
            pm_q   <= '0;
            rv_q   <= 1'b0;
            rl_q   <= 1'b0;
            rr_q   <= '0;
            save_q <= '0;
            nia_q  <= '0;
            code_q <= '0;
            kind_q <= END_COMPLETE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        idx_q <= start_idx;
                        lim_q <= start_lim;
                        ia_q  <= inst_addr;
                        len_q <= inst_len;
                        pm_q  <= prog_mask;
                        rv_q  <= res_vec;
                        rl_q  <= res_long;
                        rr_q  <= res_reg;
                        if (start_idx >= start_lim) begin
                            save_q <= '0;
                            nia_q  <= inst_addr + ADDR_W'(inst_len);
                            code_q <= '0;
                            kind_q <= END_COMPLETE;
                        end
                    end
                end
                S_ISSUE: begin
                    if (fire) begin
                        if (cls_take) begin
                            kind_q <= cls_kind;
                            code_q <= cls_code;
                            save_q <= (cls_kind == END_COMPLETE || cls_kind == END_INHIBIT)
                                      ? idx_inc : idx_q;
                            nia_q  <= (cls_kind == END_SUPPRESS)
                                      ? ia_q + ADDR_W'(len_q) : ia_q;
                        end else if (last_elem) begin
                            save_q <= '0;
                            nia_q  <= ia_q + ADDR_W'(len_q);
                            code_q <= '0;
                            kind_q <= END_COMPLETE;
                        end else begin
                            idx_q <= idx_inc;
                        end
                    end
                end
                S_FINAL: ;
                S_TRAP:  ;
            endcase
        end
    end

    // outputs
    always_comb begin
        op_valid = (state_q == S_ISSUE);
        op_idx   = idx_q;
        wr_en    = fire && cls_write;
        done     = (state_q == S_FINAL);
        intr     = (state_q == S_TRAP);
        end_kind = kind_q;
        save_idx = save_q;
        next_ia  = nia_q;
        int_code = code_q;
    end

    // R2
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ready |=> op_valid && $stable(op_idx));

    // R2
    op_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready && !cls_take && !last_elem |=> op_valid && (op_idx == $past(op_idx) + 1'b1));

    // R3
    empty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) && start && (start_idx >= start_lim) |=> done && !op_valid);

    // R10
    trap_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready && cls_take |=> intr && !op_valid);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !op_valid);

    // R10
    end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && intr));

    // R10
    inhibit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr && (end_kind == 2'd1) |-> int_code[15]);

endmodule

// File: tb/sim_vec_elem_seq.sv
`timescale 1ns/1ps
module sim_vec_elem_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  start_idx = '0, vec_count = '0, sect_size = '0;
    logic [31:0] inst_addr = '0;
    logic [2:0]  inst_len = '0;
    logic [2:0]  prog_mask = '0;
    logic        res_vec = 1'b0, res_long = 1'b0;
    logic [3:0]  res_reg = '0;
    logic        op_valid;
    logic [7:0]  op_idx;
    logic        op_ready = 1'b0;
    logic [3:0]  op_exc = '0;
    logic        wr_en, done, intr;
    logic [1:0]  end_kind;
    logic [7:0]  save_idx;
    logic [31:0] next_ia;
    logic [15:0] int_code;

    always #5 clk = ~clk;

    vec_elem_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx),
        .vec_count(vec_count), .sect_size(sect_size), .inst_addr(inst_addr),
        .inst_len(inst_len), .prog_mask(prog_mask), .res_vec(res_vec),
        .res_long(res_long), .res_reg(res_reg), .op_valid(op_valid),
        .op_idx(op_idx), .op_ready(op_ready), .op_exc(op_exc), .wr_en(wr_en),
        .done(done), .intr(intr), .end_kind(end_kind), .save_idx(save_idx),
        .next_ia(next_ia), .int_code(int_code)
    );

    typedef struct packed {
        logic [7:0] sidx;
        logic [7:0] vcnt;
        logic [7:0] ssz;
        logic [7:0] fidx;
        logic [3:0] fcode;
        logic [2:0] pm;
        logic       xintr;
        logic [1:0] xkind;
        logic [7:0] xsave;
        logic       xadv;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{8'd0, 8'd5,  8'd16, 8'd255, 4'd0, 3'd0, 1'b0, 2'd0, 8'd0, 1'b1}, // R4 clean run
        '{8'd0, 8'd6,  8'd16, 8'd2,   4'd1, 3'd1, 1'b1, 2'd0, 8'd3, 1'b0}, // R6 fixed ovf enabled
        '{8'd0, 8'd6,  8'd16, 8'd2,   4'd1, 3'd0, 1'b0, 2'd0, 8'd0, 1'b1}, // R5 fixed ovf masked
        '{8'd1, 8'd8,  8'd16, 8'd4,   4'd5, 3'd0, 1'b1, 2'd1, 8'd5, 1'b0}, // R7 divide
        '{8'd2, 8'd8,  8'd16, 8'd3,   4'd7, 3'd7, 1'b1, 2'd2, 8'd3, 1'b0}, // R8 nullify
        '{8'd0, 8'd4,  8'd16, 8'd1,   4'd8, 3'd0, 1'b1, 2'd3, 8'd1, 1'b1}, // R9 suppress
        '{8'd0, 8'd20, 8'd8,  8'd7,   4'd6, 3'd0, 1'b1, 2'd1, 8'd8, 1'b0}, // R12 last elem of section
        '{8'd9, 8'd9,  8'd16, 8'd255, 4'd0, 3'd0, 1'b0, 2'd0, 8'd0, 1'b1}, // R3 start==count
        '{8'd3, 8'd10, 8'd16, 8'd3,   4'd2, 3'd0, 1'b1, 2'd0, 8'd4, 1'b0}, // R6 exponent ovf
        '{8'd0, 8'd5,  8'd16, 8'd4,   4'd3, 3'd2, 1'b1, 2'd0, 8'd5, 1'b0}, // R6 underflow on last
        '{8'd0, 8'd5,  8'd16, 8'd1,   4'd4, 3'd3, 1'b0, 2'd0, 8'd0, 1'b1}, // R5 significance masked
        '{8'd0, 8'd3,  8'd16, 8'd0,   4'd9, 3'd7, 1'b0, 2'd0, 8'd0, 1'b1}, // R5 undefined code
        '{8'd5, 8'd12, 8'd4,  8'd255, 4'd0, 3'd0, 1'b0, 2'd0, 8'd0, 1'b1}  // R3 start above section
    };

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int hcnt [256];
    logic g_done, g_intr;
    logic [1:0]  g_kind;
    logic [7:0]  g_save;
    logic [31:0] g_nia;
    logic [15:0] g_code;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_code(input logic [3:0] c, input logic rv, input logic rl, input logic [3:0] rr);
        logic [7:0] lo;
        logic [7:0] hi;
        case (c)
            4'd1: lo = 8'h09;
            4'd2: lo = 8'h0C;
            4'd3: lo = 8'h0D;
            4'd4: lo = 8'h0E;
            4'd5: lo = 8'h0F;
            4'd6: lo = 8'h1E;
            4'd7: lo = 8'h11;
            4'd8: lo = 8'h04;
            default: lo = 8'h00;
        endcase
        hi = (c >= 4'd1 && c <= 4'd6) ? {1'b1, rv, (rl ? 2'b10 : 2'b01), rr} : 8'h00;
        return {hi, lo};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // runs one instruction from the current negedge until done or intr
    task automatic run_instr(input logic [7:0] sidx, input logic [7:0] vcnt, input logic [7:0] ssz,
                             input logic [7:0] fidx, input logic [3:0] fcode, input logic [2:0] pm,
                             input logic [31:0] ia, input logic [2:0] il,
                             input logic rv, input logic rl, input logic [3:0] rr);
        logic [7:0] exp_i;
        logic       wr_x;
        int         guard;
        exp_i = sidx;
        guard = 0;
        start_idx = sidx; vec_count = vcnt; sect_size = ssz; inst_addr = ia;
        inst_len = il; prog_mask = pm; res_vec = rv; res_long = rl; res_reg = rr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(done || intr) && guard < 2000) begin
            op_ready = 1'b0;
            op_exc   = 4'd0;
            if (op_valid) begin
                chk(op_idx == exp_i, "R2 order", op_idx, exp_i);
                op_ready = ((guard % 3) != 2);
                op_exc   = (op_idx == fidx) ? fcode : 4'd0;
                #1;
                wr_x = op_ready && !(op_exc >= 4'd5 && op_exc <= 4'd8);
                chk(wr_en == wr_x, "R11 write enable", wr_en, wr_x);
                if (op_ready) begin
                    if (!(op_exc == 4'd7 || op_exc == 4'd8)) hcnt[op_idx]++;
                    exp_i = exp_i + 1'b1;
                end
            end
            guard++;
            @(negedge clk);
        end
        op_ready = 1'b0;
        op_exc   = 4'd0;
        g_done = done; g_intr = intr; g_kind = end_kind;
        g_save = save_idx; g_nia = next_ia; g_code = int_code;
        @(negedge clk);
        chk(!done && !intr, "R10 one-cycle pulse", {done, intr}, 0);
    endtask

    initial begin
        for (int k = 0; k < 256; k++) hcnt[k] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!op_valid && !done && !intr && !wr_en, "R1 reset controls", {op_valid, done, intr, wr_en}, 0);
        chk(save_idx == 0 && next_ia == 0 && int_code == 0, "R1 reset fields", int_code, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!op_valid && !done && !intr, "R1 idle after reset", {op_valid, done, intr}, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic [31:0] ia;
            logic [2:0]  il;
            logic        rv, rl;
            logic [3:0]  rr;
            logic [7:0]  lim;
            v  = VT[i];
            ia = 32'h1000 + 32'(i) * 32'h40;
            il = (i % 2 == 0) ? 3'd4 : 3'd6;
            rv = (i % 2 == 1);
            rl = ((i / 2) % 2 == 1);
            rr = 4'(i + 3);
            lim = (v.vcnt > v.ssz) ? v.ssz : v.vcnt;
            for (int k = 0; k < 256; k++) hcnt[k] = 0;

            run_instr(v.sidx, v.vcnt, v.ssz, v.fidx, v.fcode, v.pm, ia, il, rv, rl, rr);
            chk(g_done == !v.xintr, "R4 done vs R10 intr", {g_done, g_intr}, {!v.xintr, v.xintr});
            chk(g_intr == v.xintr, "R10 intr", g_intr, v.xintr);
            chk(g_save == v.xsave, "R12 saved index (R6 R7 R8 R9)", g_save, v.xsave);
            chk(g_nia == (v.xadv ? ia + 32'(il) : ia), "R9 next address", g_nia, v.xadv ? ia + 32'(il) : ia);
            if (v.xintr) begin
                chk(g_kind == v.xkind, "R6 R7 R8 R9 ending kind", g_kind, v.xkind);
                chk(g_code == exp_code(v.fcode, rv, rl, rr), "R10 interruption code", g_code, exp_code(v.fcode, rv, rl, rr));
                // resume with the fault cleared
                run_instr(g_save, v.vcnt, v.ssz, 8'd255, 4'd0, v.pm, ia, il, rv, rl, rr);
                chk(g_done && !g_intr, "R12 resume completes", {g_done, g_intr}, 2'b10);
                chk(g_save == 0 && g_code == 0, "R4 final unit fields", g_save, 0);
            end else begin
                chk(g_code == 16'h0 && g_kind == 2'd0, "R4 final unit code", g_code, 0);
            end
            for (int k = 0; k < 256; k++) begin
                int want;
                want = (k >= int'(v.sidx) && k < int'(lim)) ? 1 : 0;
                if (hcnt[k] != want) chk(1'b0, "R12 element processed once", hcnt[k], want);
            end
            chk(1'b1, "R12 coverage scan", 0, 0);
        end

        // R3 directed: done follows the start edge by one cycle, nothing offered
        start_idx = 8'd7; vec_count = 8'd3; sect_size = 8'd16; inst_addr = 32'h200; inst_len = 3'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !op_valid, "R3 immediate final unit", {done, op_valid}, 2'b10);
        chk(next_ia == 32'h202, "R4 address advance", next_ia, 32'h202);
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule